// File: doc/BRIEF.md
# Bridge Reset Status and Protection Register

This block is the reset status and protection register for one side of a two-sided bridge. It keeps a sticky flag that records a fundamental reset seen on the far side. It can apply a programmed reset action that marks one of the two sides not ready. It can also fence the far side out of this side's capability registers: far-side writes are dropped, and far-side reads return zero except for one exempt register. Finally, it raises a device-wide fundamental reset request, either when software asks for one or when the external bridge reset pin is asserted while propagation is enabled in non-transparent mode.

Local software reads and writes the 8-bit register through a simple strobe port. Far-side accesses pass through the block on their way to the capability register file. Far-side writes are forwarded or suppressed. Far-side read data comes from the file and is masked on its way back. Only the power-on reset clears the register state. The far-side and external reset events that the register reports leave it untouched.

Top module: `bridge_rst_guard`

## Requirements
- R1: Bit 0 (reset-seen flag) becomes 1 on the clock edge that samples `osFundRst` high. If the same edge also sees a local write with data bit 0 set, the flag still ends up 1.
- R2: A local write with data bit 0 equal to 1 clears bit 0 on the next edge. A write with data bit 0 equal to 0 leaves bit 0 unchanged.
- R3: Bit 2 (fence enable) and bit 5 (pin propagation enable) are plain read/write bits that take the written value on the edge after the write strobe. Bits 1, 6 and 7 always read as 0.
- R4: While bit 2 is 1, `capWrEn` stays 0 for every far-side write. While bit 2 is 0, `capWrEn` equals `osReqValid & osReqWrite`, and `capWrIdx`/`capWrData` carry the request index and data.
- R5: While bit 2 is 1, `osRdData` is zero unless `osReqIdx == CTRL_IDX`, in which case it passes `capRdData`. While bit 2 is 0, it always passes `capRdData`.
- R6: Bit 3 enables the reset action and bit 4 selects it. On the internal side (`isInternal`=1), with bit 3 set, an edge that samples `osFundRst` or `osHotRst` high does one of two things. If bit 4 is 0, it sets `oppModeNotReady`. If bit 4 is 1, it sets `selfOsModeNotReady`.
- R7: When `isInternal` is 0, bits 3 and 4 read as 0, writes to them are ignored, and no reset action takes place.
- R8: A local write with data bit 7 equal to 1 makes `devRstReq` high for exactly the one cycle after that edge. A write with bit 7 equal to 0 requests nothing.
- R9: An edge that sees `extBridgeRstN` low, after it was high at the previous edge, produces a one-cycle `devRstReq`, provided bit 5 is 1 and `ntMode` is 1. Otherwise the pin produces no request. The pin and a bit-7 write on the same edge give one pulse.
- R10: After `porRstN` the register reads 0x00, both not-ready outputs are 1, and `devRstReq` is 0. Bits 0 to 5 are not changed by `osFundRst`, `osHotRst` or `extBridgeRstN` beyond the effects named in R1.
- R11: A pulse on `markOppReady` or `markSelfReady` clears the matching not-ready output on the next edge. A reset action on the same edge takes precedence and leaves the output set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| locWrEn | input | 1 | Local register write strobe |
| locWrData | input | 8 | Local write data |
| locRdData | output | 8 | Local register read value |
| osReqValid | input | 1 | Far-side access valid |
| osReqWrite | input | 1 | Far-side access is a write (config or BAR) |
| osReqIdx | input | IDX_W | Capability register index of the far-side access |
| osReqWrData | input | DATA_W | Far-side write data |
| capRdData | input | DATA_W | Read data from the capability register file at `osReqIdx` |
| osRdData | output | DATA_W | Read data returned to the far side |
| capWrEn | output | 1 | Write enable forwarded to the capability register file |
| capWrIdx | output | IDX_W | Forwarded write index |
| capWrData | output | DATA_W | Forwarded write data |
| osFundRst | input | 1 | Far-side fundamental reset detected |
| osHotRst | input | 1 | Far-side hot reset detected |
| extBridgeRstN | input | 1 | External bridge reset pin, active low |
| isInternal | input | 1 | 1 when this instance is the internal side |
| ntMode | input | 1 | Device operates in non-transparent mode |
| markOppReady | input | 1 | Pulse: far-side mode becomes ready |
| markSelfReady | input | 1 | Pulse: recorded far-side mode on this side becomes ready |
| oppModeNotReady | output | 1 | Far-side readiness mode is not ready |
| selfOsModeNotReady | output | 1 | This side's recorded far-side mode is not ready |
| devRstReq | output | 1 | One-cycle device fundamental reset request |

## Verification
Three pairs of events can fall on the same clock edge. A far-side fundamental reset can meet a software clear of the reset-seen flag. A reset action can meet a ready-marking pulse for the same mode output. A software reset write can meet an asserting edge on the external pin. The bench drives each pair on one edge on purpose. A behavioural model applies the priorities stated in R1, R11 and R9: the set wins, the action wins, and a single pulse is produced. Every output is compared with that model on every cycle, so a wrong priority or a doubled or missing pulse shows up in the cycle where it happens.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int REG_W  = 8;
  localparam int B_DET  = 0;
  localparam int B_PROT = 2;
  localparam int B_RAEN = 3;
  localparam int B_RA   = 4;
  localparam int B_PEFR = 5;
  localparam int B_FIRE = 7;

  typedef struct packed {
    logic det;
    logic prot;
    logic raen;
    logic ra;
    logic pefr;
  } brgCfg_t;

  typedef struct packed {
    logic setDet;
    logic clrDet;
    logic ldCfg;
    logic newProt;
    logic newRaen;
    logic newRa;
    logic newPefr;
    logic setOppNr;
    logic clrOppNr;
    logic setSelfNr;
    logic clrSelfNr;
    logic fireReq;
  } brgStrobe_t;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
(
  input  logic             clk,
  input  logic             porRstN,
  input  logic             locWrEn,
  input  logic [REG_W-1:0] locWrData,
  input  logic             osFundRst,
  input  logic             osHotRst,
  input  logic             extBridgeRstN,
  input  logic             isInternal,
  input  logic             ntMode,
  input  logic             markOppReady,
  input  logic             markSelfReady,
  input  brgCfg_t          cfg,
  output brgStrobe_t       stb
);
  logic extPrev;
  logic extFall;
  logic osRstSeen;
  logic actArm;
  logic unusedWrBits;

  // Previous pin level, so that only the asserting edge is acted on.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) extPrev <= 1'b1;
    else          extPrev <= extBridgeRstN;
  end

  assign extFall      = extPrev & ~extBridgeRstN;
  assign osRstSeen    = osFundRst | osHotRst;
  assign actArm       = isInternal & cfg.raen & osRstSeen;
  assign unusedWrBits = ^{locWrData[1], locWrData[6]};

  always_comb begin
    stb           = '0;
    stb.setDet    = osFundRst;
    stb.clrDet    = locWrEn & locWrData[B_DET];
    stb.ldCfg     = locWrEn;
    stb.newProt   = locWrData[B_PROT];
    stb.newRaen   = isInternal & locWrData[B_RAEN];
    stb.newRa     = isInternal & locWrData[B_RA];
    stb.newPefr   = locWrData[B_PEFR];
    stb.setOppNr  = actArm & ~cfg.ra;
    stb.setSelfNr = actArm & cfg.ra;
    stb.clrOppNr  = markOppReady;
    stb.clrSelfNr = markSelfReady;
    stb.fireReq   = (locWrEn & locWrData[B_FIRE]) | (cfg.pefr & ntMode & extFall);
  end

  // R7: the external side never issues a reset action
  p_no_action_ext_r7: assert property (@(posedge clk) disable iff (!porRstN)
    !isInternal |-> !(stb.setOppNr || stb.setSelfNr));

  // R9: a held-low pin fires at most once
  p_pin_once_r9: assert property (@(posedge clk) disable iff (!porRstN)
    (!extBridgeRstN && !extPrev) |-> !(stb.fireReq && !(locWrEn && locWrData[B_FIRE])));
endmodule

// File: rtl/brg_dp.sv
module brg_dp
  import brg_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int DATA_W   = 32,
  parameter int CTRL_IDX = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  brgStrobe_t        stb,
  input  logic              isInternal,
  output brgCfg_t           cfg,
  output logic [REG_W-1:0]  locRdData,
  input  logic              osReqValid,
  input  logic              osReqWrite,
  input  logic [IDX_W-1:0]  osReqIdx,
  input  logic [DATA_W-1:0] osReqWrData,
  input  logic [DATA_W-1:0] capRdData,
  output logic [DATA_W-1:0] osRdData,
  output logic              capWrEn,
  output logic [IDX_W-1:0]  capWrIdx,
  output logic [DATA_W-1:0] capWrData,
  output logic              oppModeNotReady,
  output logic              selfOsModeNotReady,
  output logic              devRstReq
);
  localparam logic [IDX_W-1:0] EXEMPT_IDX = IDX_W'(CTRL_IDX);

  brgCfg_t cfgQ;
  logic    exemptHit;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cfgQ               <= '0;
      oppModeNotReady    <= 1'b1;
      selfOsModeNotReady <= 1'b1;
      devRstReq          <= 1'b0;
    end else begin
      if (stb.setDet)      cfgQ.det <= 1'b1;
      else if (stb.clrDet) cfgQ.det <= 1'b0;
      if (stb.ldCfg) begin
        cfgQ.prot <= stb.newProt;
        cfgQ.raen <= stb.newRaen;
        cfgQ.ra   <= stb.newRa;
        cfgQ.pefr <= stb.newPefr;
      end
      if (stb.setOppNr)      oppModeNotReady <= 1'b1;
      else if (stb.clrOppNr) oppModeNotReady <= 1'b0;
      if (stb.setSelfNr)      selfOsModeNotReady <= 1'b1;
      else if (stb.clrSelfNr) selfOsModeNotReady <= 1'b0;
      devRstReq <= stb.fireReq;
    end
  end

  assign cfg = cfgQ;

  always_comb begin
    locRdData         = '0;
    locRdData[B_DET]  = cfgQ.det;
    locRdData[B_PROT] = cfgQ.prot;
    locRdData[B_RAEN] = isInternal & cfgQ.raen;
    locRdData[B_RA]   = isInternal & cfgQ.ra;
    locRdData[B_PEFR] = cfgQ.pefr;
  end

  // Far-side access fence
  assign exemptHit = (osReqIdx == EXEMPT_IDX);
  assign osRdData  = (cfgQ.prot && !exemptHit) ? '0 : capRdData;
  assign capWrEn   = osReqValid & osReqWrite & ~cfgQ.prot;
  assign capWrIdx  = osReqIdx;
  assign capWrData = osReqWrData;

  // R4: fenced writes never reach the register file
  p_fence_wr_r4: assert property (@(posedge clk) disable iff (!porRstN)
    cfgQ.prot |-> !capWrEn);

  // R6: an action strobe always leaves the selected output set
  p_opp_action_r6: assert property (@(posedge clk) disable iff (!porRstN)
    stb.setOppNr |=> oppModeNotReady);
  p_self_action_r6: assert property (@(posedge clk) disable iff (!porRstN)
    stb.setSelfNr |=> selfOsModeNotReady);

  // R11: a ready mark without an action clears the output
  p_mark_opp_r11: assert property (@(posedge clk) disable iff (!porRstN)
    (stb.clrOppNr && !stb.setOppNr) |=> !oppModeNotReady);
endmodule

// File: rtl/bridge_rst_guard.sv
module bridge_rst_guard
  import brg_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int DATA_W   = 32,
  parameter int CTRL_IDX = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              locWrEn,
  input  logic [7:0]        locWrData,
  output logic [7:0]        locRdData,
  input  logic              osReqValid,
  input  logic              osReqWrite,
  input  logic [IDX_W-1:0]  osReqIdx,
  input  logic [DATA_W-1:0] osReqWrData,
  input  logic [DATA_W-1:0] capRdData,
  output logic [DATA_W-1:0] osRdData,
  output logic              capWrEn,
  output logic [IDX_W-1:0]  capWrIdx,
  output logic [DATA_W-1:0] capWrData,
  input  logic              osFundRst,
  input  logic              osHotRst,
  input  logic              extBridgeRstN,
  input  logic              isInternal,
  input  logic              ntMode,
  input  logic              markOppReady,
  input  logic              markSelfReady,
  output logic              oppModeNotReady,
  output logic              selfOsModeNotReady,
  output logic              devRstReq
);
  brgCfg_t    cfg;
  brgStrobe_t stb;

  brg_ctrl u_ctrl (
    .clk(clk), .porRstN(porRstN), .locWrEn(locWrEn), .locWrData(locWrData),
    .osFundRst(osFundRst), .osHotRst(osHotRst), .extBridgeRstN(extBridgeRstN),
    .isInternal(isInternal), .ntMode(ntMode), .markOppReady(markOppReady),
    .markSelfReady(markSelfReady), .cfg(cfg), .stb(stb)
  );

  brg_dp #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CTRL_IDX(CTRL_IDX)) u_dp (
    .clk(clk), .porRstN(porRstN), .stb(stb), .isInternal(isInternal), .cfg(cfg),
    .locRdData(locRdData), .osReqValid(osReqValid), .osReqWrite(osReqWrite),
    .osReqIdx(osReqIdx), .osReqWrData(osReqWrData), .capRdData(capRdData),
    .osRdData(osRdData), .capWrEn(capWrEn), .capWrIdx(capWrIdx), .capWrData(capWrData),
    .oppModeNotReady(oppModeNotReady), .selfOsModeNotReady(selfOsModeNotReady),
    .devRstReq(devRstReq)
  );

  // R1: a detected far-side fundamental reset is always visible next cycle
  p_detect_r1: assert property (@(posedge clk) disable iff (!porRstN)
    osFundRst |=> locRdData[0]);

  // R3: reserved and self-clearing bits read zero
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!porRstN)
    (locRdData[7:6] == 2'b00) && !locRdData[1]);

  // R7: action fields hidden on the external side
  p_ext_hidden_r7: assert property (@(posedge clk) disable iff (!porRstN)
    !isInternal |-> (locRdData[4:3] == 2'b00));

  // R8: a request needs a software trigger or an asserted pin one edge earlier
  p_req_source_r8: assert property (@(posedge clk) disable iff (!porRstN)
    devRstReq |-> ($past(locWrEn && locWrData[7]) || $past(!extBridgeRstN && ntMode)));
endmodule

// File: tb/test_bridge_rst_guard.sv
`timescale 1ns/1ps
module test_bridge_rst_guard;
  localparam int IDX_W = 6;
  localparam int DATA_W = 32;
  localparam int CTRL_IDX = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic porRstN, locWrEn, osReqValid, osReqWrite, osFundRst, osHotRst;
  logic extBridgeRstN, isInternal, ntMode, markOppReady, markSelfReady;
  logic [7:0] locWrData, locRdData;
  logic [IDX_W-1:0] osReqIdx, capWrIdx;
  logic [DATA_W-1:0] osReqWrData, capRdData, osRdData, capWrData;
  logic capWrEn, oppModeNotReady, selfOsModeNotReady, devRstReq;

  bridge_rst_guard #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CTRL_IDX(CTRL_IDX)) i_bridge_rst_guard (
    .clk(clk), .porRstN(porRstN), .locWrEn(locWrEn), .locWrData(locWrData),
    .locRdData(locRdData), .osReqValid(osReqValid), .osReqWrite(osReqWrite),
    .osReqIdx(osReqIdx), .osReqWrData(osReqWrData), .capRdData(capRdData),
    .osRdData(osRdData), .capWrEn(capWrEn), .capWrIdx(capWrIdx), .capWrData(capWrData),
    .osFundRst(osFundRst), .osHotRst(osHotRst), .extBridgeRstN(extBridgeRstN),
    .isInternal(isInternal), .ntMode(ntMode), .markOppReady(markOppReady),
    .markSelfReady(markSelfReady), .oppModeNotReady(oppModeNotReady),
    .selfOsModeNotReady(selfOsModeNotReady), .devRstReq(devRstReq)
  );

  int checks = 0;
  int errors = 0;
  bit checkOn = 1'b0;
  bit finished = 1'b0;

  // Behavioural reference state
  bit mDet, mProt, mRaen, mRa, mPefr, mOppNr, mSelfNr, mReq, mExtPrev;

  always @(posedge clk) begin
    if (!porRstN) begin
      {mDet, mProt, mRaen, mRa, mPefr, mReq} = '0;
      mOppNr = 1; mSelfNr = 1; mExtPrev = 1;
    end else begin
      bit act, nDet, nOpp, nSelf, nReq;
      act   = isInternal && mRaen && (osFundRst || osHotRst);
      nDet  = osFundRst ? 1'b1 : ((locWrEn && locWrData[0]) ? 1'b0 : mDet);
      nOpp  = (act && !mRa) ? 1'b1 : (markOppReady ? 1'b0 : mOppNr);
      nSelf = (act && mRa) ? 1'b1 : (markSelfReady ? 1'b0 : mSelfNr);
      nReq  = (locWrEn && locWrData[7]) || (mPefr && ntMode && mExtPrev && !extBridgeRstN);
      if (locWrEn) begin
        mProt = locWrData[2];
        mPefr = locWrData[5];
        mRaen = isInternal && locWrData[3];
        mRa   = isInternal && locWrData[4];
      end
      mDet = nDet; mOppNr = nOpp; mSelfNr = nSelf; mReq = nReq;
      mExtPrev = extBridgeRstN;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checkOn) begin
      logic [7:0] expRd;
      logic [31:0] expOs;
      expRd = {2'b00, mPefr, isInternal & mRa, isInternal & mRaen, mProt, 1'b0, mDet};
      expOs = (mProt && osReqIdx != IDX_W'(CTRL_IDX)) ? 32'h0 : capRdData;
      chk("R1 R2 R3 R7 R10 locRdData", 32'(locRdData), 32'(expRd));
      chk("R5 osRdData", osRdData, expOs);
      chk("R4 capWrEn", 32'(capWrEn), 32'(osReqValid && osReqWrite && !mProt));
      chk("R4 capWrIdx/data", {capWrData[25:0], capWrIdx}, {osReqWrData[25:0], osReqIdx});
      chk("R6 R11 oppModeNotReady", 32'(oppModeNotReady), 32'(mOppNr));
      chk("R6 R11 selfOsModeNotReady", 32'(selfOsModeNotReady), 32'(mSelfNr));
      chk("R8 R9 devRstReq", 32'(devRstReq), 32'(mReq));
    end
  end

  assign capRdData = 32'hC0DE_0000 | 32'(osReqIdx);

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic idle();
    locWrEn = 0; osFundRst = 0; osHotRst = 0; markOppReady = 0; markSelfReady = 0;
    osReqValid = 0;
  endtask

  task automatic wr(logic [7:0] d);
    locWrEn = 1; locWrData = d; tick(); locWrEn = 0; tick();
  endtask

  task automatic farAcc(bit w, int idx);
    osReqValid = 1; osReqWrite = w; osReqIdx = IDX_W'(idx);
    osReqWrData = 32'h1234_5600 | 32'(idx); tick(); osReqValid = 0; tick();
  endtask

  initial begin
    porRstN = 0; idle(); locWrData = 0; osReqWrite = 0; osReqIdx = 0; osReqWrData = 0;
    extBridgeRstN = 1; isInternal = 1; ntMode = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1; porRstN = 1; checkOn = 1;
    tick(2);                                       // R10 reset state
    // R3: read/write bits
    wr(8'h24); wr(8'hC2);                          // R3 reserved / bit7 pulse R8
    wr(8'h04);
    // R4 R5: fenced far-side access
    farAcc(1, CTRL_IDX); farAcc(1, 5); farAcc(0, CTRL_IDX); farAcc(0, 9);
    wr(8'h00);
    farAcc(1, 5); farAcc(0, 9); farAcc(0, CTRL_IDX);
    // R1 R2: detection and clearing
    osFundRst = 1; tick(); osFundRst = 0; tick();
    wr(8'h00); wr(8'h01);
    osFundRst = 1; locWrEn = 1; locWrData = 8'h01; tick(); idle(); tick();  // R1 collision
    wr(8'h01);
    // R11: mark ready
    markOppReady = 1; tick(); markOppReady = 0; markSelfReady = 1; tick(); idle(); tick();
    // R6: action to far side
    wr(8'h08);
    osHotRst = 1; tick(); idle(); markOppReady = 1; tick(); idle(); tick();
    wr(8'h18);
    osFundRst = 1; tick(); idle(); tick();
    osHotRst = 1; markSelfReady = 1; markOppReady = 1; tick(); idle(); tick(); // R11 collision
    markSelfReady = 1; tick(); idle();
    wr(8'h00); osHotRst = 1; tick(); idle(); tick(); // action disabled
    // R7: external side
    isInternal = 0; wr(8'h18); osFundRst = 1; osHotRst = 1; tick(); idle(); tick();
    isInternal = 1; tick(); wr(8'h08); isInternal = 0; osHotRst = 1; tick(); idle(); tick();
    isInternal = 1;
    // R8: back-to-back software requests
    locWrEn = 1; locWrData = 8'h80; tick(2); idle(); tick(2);
    // R9: pin propagation
    wr(8'h20);
    extBridgeRstN = 0; tick(3); extBridgeRstN = 1; tick();
    ntMode = 0; extBridgeRstN = 0; tick(); extBridgeRstN = 1; tick(); ntMode = 1;
    extBridgeRstN = 0; locWrEn = 1; locWrData = 8'hA0; tick(); idle(); extBridgeRstN = 1; tick(2);
    wr(8'h00); extBridgeRstN = 0; tick(); extBridgeRstN = 1; tick();
    // R10: persistence across reported resets, then power-on clear
    wr(8'h3C); osFundRst = 1; tick(); osFundRst = 0; osHotRst = 1; tick(); idle();
    extBridgeRstN = 0; tick(2); extBridgeRstN = 1; tick(3);
    porRstN = 0; tick(); porRstN = 1; tick(3);
    checkOn = 0; finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule